// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block is a single-channel master DMA engine that works through a chain of transfer descriptors kept in memory. Software points it at the first descriptor and arms it. From then on, one trigger pulse is enough to run the whole chain. The trigger may come from software or from another DMA channel's transfer-complete line. For every descriptor the engine reads the six descriptor words, copies the requested number of words from source to destination, and can then write a mask value to a programmed address. That last write acknowledges the upstream channel that raised the trigger. After that the engine follows the descriptor's link pointer.

A zero link ends the chain. The engine then raises a sticky done interrupt and goes back to waiting at the head descriptor. A link that points back to an earlier descriptor makes the transfer circular, so it never ends by itself. While the engine is busy it holds one early trigger and counts any further ones as overruns. An abort request brings the engine back to idle at the next word boundary.

Memory is reached through a single-beat request/acknowledge port. Each request holds its address, direction and write data until the acknowledge arrives, and read data is taken in the acknowledge cycle. Addresses are byte addresses with a fixed 4-byte word stride.

Top module: `chain_dma`

## Requirements
- R1: After reset, mem_req, irq_done and busy are 0 and ovr_count is 0.
- R2: Until cfg_start arms the engine, trig_in pulses are ignored. After arming, the engine issues no memory access until a trigger arrives. Whenever busy is 0, mem_req is 0.
- R3: A descriptor at address P occupies six words, read in this order: P+0 source address, P+4 destination address, P+8 word count, P+12 clear address, P+16 clear mask, P+20 link pointer.
- R4: For a count of N, the engine reads source+4*i and then writes that value to destination+4*i, for i = 0 to N-1 in ascending order.
- R5: A descriptor whose count is 0 performs no data reads and no data writes.
- R6: After the copy, the engine writes the clear mask to the clear address. A clear address of 0 skips this write.
- R7: A non-zero link makes the engine fetch the descriptor at that address without any new trigger, so one trigger runs the whole chain.
- R8: When a descriptor with link 0 completes, irq_done rises with busy at 0 and the engine returns to waiting at the head address. irq_done stays set until irq_ack is high. If the completion and irq_ack fall in the same cycle, the completion wins.
- R9: A link that points back to the head descriptor repeats the chain with no end and never raises irq_done.
- R10: One trigger that arrives while busy is held and starts a new run as soon as the current chain completes. Each further trigger during the same busy time adds 1 to ovr_count, which saturates at its maximum. cfg_start clears ovr_count.
- R11: A cfg_abort pulse returns the engine to idle once the access in flight ends. No further memory access follows, any held trigger is dropped, and later triggers are ignored until the next cfg_start.
- R12: While mem_req is high and mem_ack is low, mem_addr, mem_we and mem_wdata hold their values and mem_req stays high.

Top module port list (continued below).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Pulse: arm the engine at cfg_head (taken only when idle) |
| cfg_abort | input | 1 | Pulse: stop at the next word boundary and go idle |
| cfg_head | input | AW | Byte address of the first descriptor |
| irq_ack | input | 1 | Clears irq_done |
| trig_in | input | 1 | Trigger pulse, e.g. an upstream transfer-complete |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | DW | Read data |
| irq_done | output | 1 | Sticky chain-complete interrupt |
| busy | output | 1 | A chain is being processed |
| ovr_count | output | OVW | Saturating count of dropped triggers |

## Verification
Two functions can fall in one cycle: the sticky done flag being set by a finishing chain, and its clear by irq_ack. The bench provokes this by holding irq_ack high for a whole chain, so the acknowledge is present in the exact cycle the last descriptor completes. It judges the result by requiring irq_done to be seen high for exactly one sample, then low on the next. A second overlap occurs when a held trigger is consumed: a trigger arriving during the busy time must start a new run the moment the first run's done flag is raised, and the write count at that moment must show that only the first run has written.

// File: rtl/chain_dma_pkg.sv
`timescale 1ns/1ps
package chain_dma_pkg;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_CLEAR,
    ST_NEXT
  } seq_state_t;

  // Descriptor word positions (fetch order matters: count and clear
  // address are loaded before the link word closes the fetch)
  localparam int unsigned NODE_WORDS = 6;
  localparam int unsigned FLD_SRC    = 0;
  localparam int unsigned FLD_DST    = 1;
  localparam int unsigned FLD_CNT    = 2;
  localparam int unsigned FLD_CLRA   = 3;
  localparam int unsigned FLD_MASK   = 4;
  localparam int unsigned FLD_LINK   = 5;

  localparam int unsigned BYTES_PER_WORD = 4;
  localparam int unsigned WORD_SHIFT     = $clog2(BYTES_PER_WORD);

endpackage

// File: rtl/chain_dma_desc.sv
`timescale 1ns/1ps
// Descriptor register file: loaded word by word during fetch, pointer and
// count fields advance on each completed data write.
module chain_dma_desc
  import chain_dma_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NF = NODE_WORDS,
  parameter int unsigned IW = $clog2(NF)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_en_i,
  input  logic [IW-1:0]          ld_idx_i,
  input  logic [DW-1:0]          ld_data_i,
  input  logic                   step_i,
  output logic [NF-1:0][DW-1:0]  fld_o
);

  localparam logic [DW-1:0] STRIDE = DW'(BYTES_PER_WORD);

  for (genvar g = 0; g < NF; g++) begin : g_fld
    localparam bit IS_PTR = (g == FLD_SRC) || (g == FLD_DST);
    localparam bit IS_CNT = (g == FLD_CNT);

    logic [DW-1:0] word_q;
    logic [DW-1:0] word_n;
    logic          word_en;

    always_comb begin
      word_en = 1'b0;
      word_n  = word_q;
      if (ld_en_i && (ld_idx_i == IW'(g))) begin
        word_en = 1'b1;
        word_n  = ld_data_i;
      end else if (step_i) begin
        if (IS_PTR) begin
          word_en = 1'b1;
          word_n  = word_q + STRIDE;
        end else if (IS_CNT) begin
          word_en = 1'b1;
          word_n  = word_q - DW'(1);
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_n;
      end
    end

    assign fld_o[g] = word_q;
  end

endmodule

// File: rtl/chain_dma_trig.sv
`timescale 1ns/1ps
// Trigger front end: direct start while waiting, one-deep hold while busy,
// saturating overrun count for anything beyond that.
module chain_dma_trig #(
  parameter int unsigned OVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           trig_i,
  input  logic           armed_i,
  input  logic           waiting_i,
  input  logic           flush_i,
  input  logic           ovr_clr_i,
  output logic           go_o,
  output logic [OVW-1:0] ovr_o
);

  logic           pend_q, pend_n, pend_en;
  logic [OVW-1:0] ovr_q, ovr_n;
  logic           ovr_inc, ovr_en;

  assign go_o = waiting_i & (pend_q | trig_i);

  always_comb begin
    if (flush_i || !armed_i) begin
      pend_n = 1'b0;
    end else if (waiting_i) begin
      // held trigger is consumed; a fresh one in the same cycle is kept
      pend_n = pend_q & trig_i;
    end else begin
      pend_n = pend_q | trig_i;
    end
    pend_en = (pend_n != pend_q);

    ovr_inc = armed_i & ~waiting_i & ~flush_i & trig_i & pend_q & (ovr_q != '1);
    ovr_n   = ovr_clr_i ? '0 : ovr_q + OVW'(1);
    ovr_en  = ovr_clr_i | ovr_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= '0;
    end else if (ovr_en) begin
      ovr_q <= ovr_n;
    end
  end

  assign ovr_o = ovr_q;

endmodule

// File: rtl/chain_dma_seq.sv
`timescale 1ns/1ps
// Chain sequencer: fetch, copy, clear write, link follow, abort and done flag.
module chain_dma_seq
  import chain_dma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned NF = NODE_WORDS,
  parameter int unsigned IW = $clog2(NF)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_start_i,
  input  logic                  cfg_abort_i,
  input  logic [AW-1:0]         cfg_head_i,
  input  logic                  irq_ack_i,
  input  logic                  go_i,
  input  logic                  mem_ack_i,
  input  logic [DW-1:0]         mem_rdata_i,
  input  logic [NF-1:0][DW-1:0] fld_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [DW-1:0]         mem_wdata_o,
  output logic                  ld_en_o,
  output logic [IW-1:0]         ld_idx_o,
  output logic [DW-1:0]         ld_data_o,
  output logic                  step_o,
  output logic                  armed_o,
  output logic                  waiting_o,
  output logic                  flush_o,
  output logic                  ovr_clr_o,
  output logic                  busy_o,
  output logic                  irq_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NF - 1);

  seq_state_t    state_q, state_n;
  logic [IW-1:0] fidx_q, fidx_n;
  logic [AW-1:0] node_q, node_n;
  logic [AW-1:0] head_q;
  logic [DW-1:0] buf_q;
  logic          abort_q, abort_n;
  logic          irq_q, irq_n;

  logic          fidx_en, node_en, head_en, buf_en;
  logic          acc_done, abort_now, to_idle, irq_set;
  seq_state_t    post_fetch;

  logic [AW-1:0] src_a, dst_a, clr_a, link_a;
  logic [DW-1:0] cnt_w;

  assign src_a  = fld_i[FLD_SRC][AW-1:0];
  assign dst_a  = fld_i[FLD_DST][AW-1:0];
  assign clr_a  = fld_i[FLD_CLRA][AW-1:0];
  assign link_a = fld_i[FLD_LINK][AW-1:0];
  assign cnt_w  = fld_i[FLD_CNT];

  // Memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = node_q + (AW'(fidx_q) << WORD_SHIFT);
      end
      ST_READ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_a;
      end
      ST_WRITE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_a;
        mem_wdata_o = buf_q;
      end
      ST_CLEAR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = clr_a;
        mem_wdata_o = fld_i[FLD_MASK];
      end
      default: ;
    endcase
  end

  assign acc_done  = mem_req_o & mem_ack_i;
  assign abort_now = abort_q | cfg_abort_i;

  assign ld_en_o   = (state_q == ST_FETCH) & mem_ack_i;
  assign ld_idx_o  = fidx_q;
  assign ld_data_o = mem_rdata_i;
  assign step_o    = (state_q == ST_WRITE) & mem_ack_i;

  always_comb begin
    if (cnt_w != '0)      post_fetch = ST_READ;
    else if (clr_a != '0) post_fetch = ST_CLEAR;
    else                  post_fetch = ST_NEXT;
  end

  // Next-state logic
  always_comb begin
    state_n = state_q;
    fidx_n  = fidx_q;
    fidx_en = 1'b0;
    node_n  = node_q;
    node_en = 1'b0;
    to_idle = 1'b0;
    irq_set = 1'b0;
    head_en = 1'b0;
    buf_en  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (cfg_start_i) begin
          state_n = ST_WAIT;
          head_en = 1'b1;
          node_n  = cfg_head_i;
          node_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (abort_now) begin
          to_idle = 1'b1;
        end else if (go_i) begin
          state_n = ST_FETCH;
          fidx_n  = '0;
          fidx_en = 1'b1;
        end
      end
      ST_FETCH: begin
        if (acc_done) begin
          if (abort_now) begin
            to_idle = 1'b1;
          end else if (fidx_q == LAST_IDX) begin
            fidx_n  = '0;
            fidx_en = 1'b1;
            state_n = post_fetch;
          end else begin
            fidx_n  = fidx_q + IW'(1);
            fidx_en = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (acc_done) begin
          buf_en = 1'b1;
          if (abort_now) to_idle = 1'b1;
          else           state_n = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (acc_done) begin
          if (abort_now) begin
            to_idle = 1'b1;
          end else if (cnt_w == DW'(1)) begin
            state_n = (clr_a != '0) ? ST_CLEAR : ST_NEXT;
          end else begin
            state_n = ST_READ;
          end
        end
      end
      ST_CLEAR: begin
        if (acc_done) begin
          if (abort_now) to_idle = 1'b1;
          else           state_n = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (abort_now) begin
          to_idle = 1'b1;
        end else if (link_a == '0) begin
          irq_set = 1'b1;
          node_n  = head_q;
          node_en = 1'b1;
          state_n = ST_WAIT;
        end else begin
          node_n  = link_a;
          node_en = 1'b1;
          fidx_n  = '0;
          fidx_en = 1'b1;
          state_n = ST_FETCH;
        end
      end
      default: state_n = ST_IDLE;
    endcase

    if (to_idle) state_n = ST_IDLE;

    if (to_idle || (state_q == ST_IDLE)) abort_n = 1'b0;
    else                                 abort_n = abort_q | cfg_abort_i;

    irq_n = irq_set | (irq_q & ~irq_ack_i);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      abort_q <= abort_n;
      irq_q   <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fidx_q <= '0;
    end else if (fidx_en) begin
      fidx_q <= fidx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q <= '0;
    end else if (node_en) begin
      node_q <= node_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
    end else if (head_en) begin
      head_q <= cfg_head_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= mem_rdata_i;
    end
  end

  assign armed_o   = (state_q != ST_IDLE);
  assign waiting_o = (state_q == ST_WAIT);
  assign busy_o    = (state_q != ST_IDLE) && (state_q != ST_WAIT);
  assign flush_o   = to_idle;
  assign ovr_clr_o = (state_q == ST_IDLE) & cfg_start_i;
  assign irq_o     = irq_q;

endmodule

// File: rtl/chain_dma.sv
`timescale 1ns/1ps
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned OVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_start,
  input  logic           cfg_abort,
  input  logic [AW-1:0]  cfg_head,
  input  logic           irq_ack,
  input  logic           trig_in,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [DW-1:0]  mem_rdata,
  output logic           irq_done,
  output logic           busy,
  output logic [OVW-1:0] ovr_count
);

  localparam int unsigned NF = NODE_WORDS;
  localparam int unsigned IW = $clog2(NF);

  logic [NF-1:0][DW-1:0] fld;
  logic                  ld_en;
  logic [IW-1:0]         ld_idx;
  logic [DW-1:0]         ld_data;
  logic                  step;
  logic                  go, armed, waiting, flush, ovr_clr;

  chain_dma_trig #(.OVW(OVW)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (trig_in),
    .armed_i   (armed),
    .waiting_i (waiting),
    .flush_i   (flush),
    .ovr_clr_i (ovr_clr),
    .go_o      (go),
    .ovr_o     (ovr_count)
  );

  chain_dma_desc #(.DW(DW), .NF(NF), .IW(IW)) u_desc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en_i   (ld_en),
    .ld_idx_i  (ld_idx),
    .ld_data_i (ld_data),
    .step_i    (step),
    .fld_o     (fld)
  );

  chain_dma_seq #(.AW(AW), .DW(DW), .NF(NF), .IW(IW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_start_i (cfg_start),
    .cfg_abort_i (cfg_abort),
    .cfg_head_i  (cfg_head),
    .irq_ack_i   (irq_ack),
    .go_i        (go),
    .mem_ack_i   (mem_ack),
    .mem_rdata_i (mem_rdata),
    .fld_i       (fld),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .ld_en_o     (ld_en),
    .ld_idx_o    (ld_idx),
    .ld_data_o   (ld_data),
    .step_o      (step),
    .armed_o     (armed),
    .waiting_o   (waiting),
    .flush_o     (flush),
    .ovr_clr_o   (ovr_clr),
    .busy_o      (busy),
    .irq_o       (irq_done)
  );

endmodule

// File: rtl/chain_dma_chk.sv
`timescale 1ns/1ps
module chain_dma_chk #(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned OVW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           mem_ack,
  input logic           irq_done,
  input logic           irq_ack,
  input logic           busy,
  input logic [OVW-1:0] ovr_count
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

  AST_NO_ACCESS_UNBUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R2

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !irq_ack) |=> irq_done); // R8

  AST_IRQ_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> !busy); // R8

  AST_OVR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_count) |-> ((ovr_count == OVW'($past(ovr_count) + OVW'(1))) || (ovr_count == '0))); // R10

endmodule

bind chain_dma chain_dma_chk #(.AW(AW), .DW(DW), .OVW(OVW)) u_chk (.*);

// File: tb/chain_dma_test.sv
`timescale 1ns/1ps
module chain_dma_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_start, cfg_abort, irq_ack, trig_in;
  logic [31:0] cfg_head;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq_done, busy;
  logic [7:0]  ovr_count;

  chain_dma uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_abort(cfg_abort),
    .cfg_head(cfg_head), .irq_ack(irq_ack), .trig_in(trig_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq_done(irq_done), .busy(busy), .ovr_count(ovr_count)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // memory model state and logs
  logic [31:0] mem [0:1023];
  logic [31:0] rd_addr [0:255];
  logic [31:0] wr_addr [0:255];
  logic [31:0] wr_data [0:255];
  int          rd_n = 0;
  int          wr_n = 0;
  int          lat  = 0;
  int          stall = 0;
  int          proto_err = 0;
  bit          seen = 0;
  logic [31:0] h_addr, h_wd;
  logic        h_we;

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  // single-beat memory responder, acts on falling edges
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        seen    = 1'b0;
      end else if (rst_n && mem_req) begin
        if (!seen) begin
          seen = 1'b1; stall = 0;
          h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
        end else if (mem_addr !== h_addr || mem_we !== h_we || mem_wdata !== h_wd) begin
          proto_err++;
        end
        if (stall >= lat) begin
          mem_ack = 1'b1;
          if (mem_we) begin
            mem[mem_addr[11:2]] = mem_wdata;
            if (wr_n < 256) begin wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; end
            wr_n++;
          end else begin
            mem_rdata = mem[mem_addr[11:2]];
            if (rd_n < 256) rd_addr[rd_n] = mem_addr;
            rd_n++;
          end
        end else begin
          stall++;
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_logs();
    rd_n = 0; wr_n = 0; proto_err = 0;
  endtask

  task automatic put_node(input logic [31:0] at, input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] cnt, input logic [31:0] clra, input logic [31:0] mask,
                          input logic [31:0] link);
    mem[at[11:2]]     = src;
    mem[at[11:2] + 1] = dst;
    mem[at[11:2] + 2] = cnt;
    mem[at[11:2] + 3] = clra;
    mem[at[11:2] + 4] = mask;
    mem[at[11:2] + 5] = link;
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1; tick(); trig_in = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic arm(input logic [31:0] head);
    cfg_abort = 1'b1; tick(); cfg_abort = 1'b0;
    repeat (3) tick();
    cfg_head = head; cfg_start = 1'b1; tick(); cfg_start = 1'b0;
    tick();
  endtask

  task automatic wait_irq(input int lim, output bit got);
    got = 1'b0;
    for (int i = 0; i < lim && !got; i++) begin
      tick();
      if (irq_done) got = 1'b1;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 irq_done", {31'd0, irq_done}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ovr_count", {24'd0, ovr_count}, 32'd0);
  endtask

  task automatic t_unarmed();
    clr_logs();
    pulse_trig();
    repeat (20) tick();
    chk("R2 unarmed trigger ignored: reads", rd_n, 0);
    chk("R2 unarmed busy", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_single();
    bit got;
    for (int i = 0; i < 8; i++) mem[('h400 >> 2) + i] = 32'hC0DE0000 + i;
    put_node(32'h100, 32'h400, 32'h600, 3, 32'h800, 32'hA5, 0);
    arm(32'h100);
    clr_logs();
    repeat (10) tick();
    chk("R2 armed, no access before trigger", rd_n + wr_n, 0);
    pulse_trig();
    wait_irq(300, got);
    chk("R8 done raised", {31'd0, got}, 32'd1);
    chk("R8 busy low at done", {31'd0, busy}, 32'd0);
    for (int k = 0; k < 6; k++) chk("R3 descriptor word order", rd_addr[k], 32'h100 + 4 * k);
    chk("R4 first data read", rd_addr[6], 32'h400);
    chk("R4 reads total", rd_n, 9);
    chk("R4 write count", wr_n, 4);
    for (int k = 0; k < 3; k++) begin
      chk("R4 write address order", wr_addr[k], 32'h600 + 4 * k);
      chk("R4 copied data", mem[('h600 >> 2) + k], 32'hC0DE0000 + k);
    end
    chk("R6 clear write address", wr_addr[3], 32'h800);
    chk("R6 clear write mask", wr_data[3], 32'hA5);
    repeat (5) tick();
    chk("R8 sticky without ack", {31'd0, irq_done}, 32'd1);
    pulse_ack();
    chk("R8 cleared by ack", {31'd0, irq_done}, 32'd0);
  endtask

  task automatic t_chain();
    bit got;
    for (int i = 0; i < 8; i++) mem[('h480 >> 2) + i] = 32'hBEEF0000 + i;
    mem['h4A0 >> 2] = 32'h5A5A_0001;
    put_node(32'h140, 32'h480, 32'h680, 2, 0, 32'h77, 32'h180);
    put_node(32'h180, 0, 0, 0, 32'h804, 32'h3, 32'h1C0);
    put_node(32'h1C0, 32'h4A0, 32'h6A0, 1, 0, 32'h99, 0);
    arm(32'h140);
    lat = 3;
    clr_logs();
    pulse_trig();
    wait_irq(1500, got);
    chk("R7 chain of three completes", {31'd0, got}, 32'd1);
    chk("R7 reads over chain", rd_n, 21);
    chk("R7 second node fetched", rd_addr[8], 32'h180);
    chk("R7 third node fetched", rd_addr[14], 32'h1C0);
    chk("R5 zero count node: writes", wr_n, 4);
    chk("R5 clear follows previous copy", wr_addr[2], 32'h804);
    chk("R6 clear mask of node two", wr_data[2], 32'h3);
    chk("R6 zero clear address skipped", wr_addr[3], 32'h6A0);
    chk("R4 third node data", mem['h6A0 >> 2], 32'h5A5A_0001);
    chk("R12 request held while stalled", proto_err, 0);
    lat = 0;
    pulse_ack();
  endtask

  task automatic t_collision();
    bit got;
    irq_ack = 1'b1;
    clr_logs();
    pulse_trig();
    got = 1'b0;
    for (int i = 0; i < 600 && !got; i++) begin
      tick();
      if (irq_done) got = 1'b1;
    end
    chk("R8 done wins over same-cycle ack", {31'd0, got}, 32'd1);
    tick();
    chk("R8 held ack clears next cycle", {31'd0, irq_done}, 32'd0);
    chk("R7 rerun from head writes", wr_n, 4);
    irq_ack = 1'b0;
  endtask

  task automatic t_pending();
    bit got;
    put_node(32'h200, 32'h500, 32'h700, 8, 32'h808, 32'h1, 0);
    arm(32'h200);
    clr_logs();
    pulse_trig();
    repeat (3) tick();
    chk("R10 busy during run", {31'd0, busy}, 32'd1);
    for (int i = 0; i < 3; i++) begin pulse_trig(); tick(); end
    chk("R10 overrun count", {24'd0, ovr_count}, 32'd2);
    wait_irq(400, got);
    chk("R10 first run done", {31'd0, got}, 32'd1);
    chk("R10 writes of first run", wr_n, 9);
    pulse_ack();
    wait_irq(400, got);
    chk("R10 held trigger ran second pass", {31'd0, got}, 32'd1);
    chk("R10 writes after second run", wr_n, 18);
    pulse_ack();
    repeat (60) tick();
    chk("R10 no third run", wr_n, 18);
    chk("R10 idle after held trigger used", {31'd0, busy}, 32'd0);
    arm(32'h200);
    chk("R10 start clears overrun", {24'd0, ovr_count}, 32'd0);
  endtask

  task automatic t_circular();
    int r0, w0;
    bit ok;
    mem['h520 >> 2] = 32'h1234_5678;
    put_node(32'h240, 32'h520, 32'h720, 1, 0, 0, 32'h240);
    arm(32'h240);
    clr_logs();
    pulse_trig();
    for (int i = 0; i < 600 && wr_n < 6; i++) tick();
    chk("R9 loop keeps writing", {31'd0, wr_n >= 6}, 32'd1);
    chk("R9 no done in loop", {31'd0, irq_done}, 32'd0);
    chk("R9 refetch of head", rd_addr[7], 32'h240);
    chk("R9 loop data", mem['h720 >> 2], 32'h1234_5678);
    pulse_trig();
    cfg_abort = 1'b1; tick(); cfg_abort = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 20 && !ok; i++) begin
      if (!busy) ok = 1'b1; else tick();
    end
    chk("R11 abort reaches idle", {31'd0, ok}, 32'd1);
    r0 = rd_n; w0 = wr_n;
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin tick(); if (mem_req) ok = 1'b0; end
    chk("R11 no request after abort", {31'd0, ok}, 32'd1);
    chk("R11 held trigger dropped", rd_n + wr_n, r0 + w0);
    pulse_trig();
    repeat (20) tick();
    chk("R11 trigger ignored after abort", rd_n + wr_n, r0 + w0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_start = 1'b0; cfg_abort = 1'b0; irq_ack = 1'b0;
    trig_in = 1'b0; cfg_head = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_unarmed();
    t_single();
    t_chain();
    t_collision();
    t_pending();
    t_circular();
    summary();
    $finish;
  end

endmodule